// File: doc/BRIEF.md
# Processor Status Word and Interrupt Acceptance Unit

This block keeps the processor status word: four arithmetic flags, a debug flag, a register-bank select, an interrupt-enable flag, a stack-select flag and a three-bit interrupt priority level. It also holds two 16-bit stack pointers, one for interrupts and one for user code, and presents whichever one the stack-select flag picks. The execution pipeline sends it ALU flag results, software writes of the whole word, stack pointer writes, software interrupt instruction events and one maskable interrupt request with its priority.

Each cycle the unit picks exactly one update kind for the status word. There is no sequencing state. From highest to lowest priority the kinds are: IRQ (a maskable request is accepted), SWI (a software interrupt instruction executes), SWWR (software writes the word), ALU (flag update) and HOLD (nothing changes). When a request is accepted, the unit raises a single-cycle accept pulse. In that same cycle it shows the unmodified word on a save output, so the stacking logic can push it. At the clock edge that ends the cycle, the word takes its new value in one atomic step.

Top module: `status_word_unit`

## Requirements
- R1: After reset the status word reads 0, both stack pointers hold 0, and the interrupt stack pointer is the active one.
- R2: `irq_accept` is high in a cycle only when `irq_req` is 1, the I flag (bit 6) is 1, `irq_prio` is strictly greater than the IPL field (bits 14:12), and `swi_exec` is 0.
- R3: On acceptance, `save_word` equals the status word before the update. At the next edge I becomes 0, IPL takes `irq_prio`, and C, D, Z, S, B and O are kept.
- R4: A software interrupt clears I. It clears U (bit 7) when `swi_num` is below 32 and leaves U unchanged when `swi_num` is 32 or more. Hardware acceptance always clears U.
- R5: U=0 selects the interrupt stack pointer and U=1 selects the user stack pointer. `sp_wr_en` loads `sp_wr_data` into the selected 16-bit pointer, and `sp_active` shows that pointer's value before the write.
- R6: `bank_sel` follows the B flag (bit 4): 0 selects bank 0 and 1 selects bank 1.
- R7: An ALU update loads C (bit 0), Z (bit 2), S (bit 3) and O (bit 5) from `alu_carry`, `alu_zero`, `alu_sign` and `alu_ovf`. All other bits are left unchanged.
- R8: The layout is C=0, D=1, Z=2, S=3, B=4, O=5, I=6, U=7 and IPL=14:12. Bits 11:8 and 15 are reserved and always read 0. A software write loads every other bit, D included.
- R9: When several updates arrive in the same cycle, they are applied in this priority order: acceptance, then software interrupt, then software write, then ALU update.
- R10: The stack pointer selection for both read and write uses the U value that results from any acceptance or software interrupt in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| alu_flag_we | input | 1 | ALU flag update strobe |
| alu_carry | input | 1 | Carry, borrow or shift-out result |
| alu_zero | input | 1 | Result was zero |
| alu_sign | input | 1 | Result was negative |
| alu_ovf | input | 1 | Result overflowed |
| sw_wr_en | input | 1 | Software write of the status word |
| sw_wr_data | input | 16 | Word to write |
| sp_wr_en | input | 1 | Write the selected stack pointer |
| sp_wr_data | input | 16 | Stack pointer value to write |
| irq_req | input | 1 | Maskable interrupt request |
| irq_prio | input | 3 | Priority of the request |
| swi_exec | input | 1 | Software interrupt instruction executes |
| swi_num | input | 6 | Software interrupt number |
| irq_accept | output | 1 | Request accepted this cycle |
| save_word | output | 16 | Status word before this cycle's update |
| status_word | output | 16 | Current status word |
| bank_sel | output | 1 | Register bank select |
| sp_active | output | 16 | Value of the selected stack pointer |

## Verification
The checker enforces the acceptance gate on every cycle: the I flag must be set, the priority comparison must be strict, and a software interrupt must not be executing. After every acceptance it confirms that I and U are cleared and that IPL is loaded with the request's priority. It also confirms that reserved bits stay 0, that high-numbered software interrupts keep U, and that the bank output follows B. The bench scenarios are needed to show the same-cycle priority between update sources, that a pointer write lands in the pointer chosen after acceptance, that the save output carries the pre-update word, and that the pointer values survive across selection changes.

// File: rtl/swu_pkg.sv
package swu_pkg;

    localparam int WORD_W   = 16;
    localparam int IPL_W    = 3;
    localparam int IPL_LSB  = 12;

    localparam int BIT_C    = 0;
    localparam int BIT_D    = 1;
    localparam int BIT_Z    = 2;
    localparam int BIT_S    = 3;
    localparam int BIT_B    = 4;
    localparam int BIT_O    = 5;
    localparam int BIT_I    = 6;
    localparam int BIT_U    = 7;

    localparam logic [WORD_W-1:0] RSVD_MASK = 16'h8F00;

    typedef enum logic [2:0] {
        UPD_HOLD,
        UPD_ALU,
        UPD_SWWR,
        UPD_SWI,
        UPD_IRQ
    } upd_kind_e;

endpackage

// File: rtl/swu_accept.sv
module swu_accept
    import swu_pkg::*;
(
    input  logic             irq_req,
    input  logic [IPL_W-1:0] irq_prio,
    input  logic             swi_exec,
    input  logic             i_flag,
    input  logic [IPL_W-1:0] cur_ipl,
    output logic             accept
);

    logic prio_above;

    always_comb begin
        prio_above = (irq_prio > cur_ipl);
        accept     = irq_req & i_flag & prio_above & ~swi_exec;
    end

endmodule

// File: rtl/swu_status_reg.sv
module swu_status_reg
    import swu_pkg::*;
#(
    parameter int SWI_NUM_W   = 6,
    parameter int SWI_U_LIMIT = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 accept,
    input  logic [IPL_W-1:0]     irq_prio,
    input  logic                 swi_exec,
    input  logic [SWI_NUM_W-1:0] swi_num,
    input  logic                 sw_wr_en,
    input  logic [WORD_W-1:0]    sw_wr_data,
    input  logic                 alu_flag_we,
    input  logic                 alu_carry,
    input  logic                 alu_zero,
    input  logic                 alu_sign,
    input  logic                 alu_ovf,
    output logic [WORD_W-1:0]    cur_word,
    output logic                 next_u
);

    localparam logic [SWI_NUM_W-1:0] U_LIM = SWI_NUM_W'(SWI_U_LIMIT);

    upd_kind_e         kind;
    logic [WORD_W-1:0] word_q;
    logic [WORD_W-1:0] word_d;

    // Pick the single update applied this cycle
    always_comb begin
        if (accept)
            kind = UPD_IRQ;
        else if (swi_exec)
            kind = UPD_SWI;
        else if (sw_wr_en)
            kind = UPD_SWWR;
        else if (alu_flag_we)
            kind = UPD_ALU;
        else
            kind = UPD_HOLD;
    end

    always_comb begin
        word_d = word_q;
        unique case (kind)
            UPD_IRQ: begin
                word_d[BIT_I]                 = 1'b0;
                word_d[BIT_U]                 = 1'b0;
                word_d[IPL_LSB +: IPL_W]      = irq_prio;
            end
            UPD_SWI: begin
                word_d[BIT_I] = 1'b0;
                if (swi_num < U_LIM)
                    word_d[BIT_U] = 1'b0;
            end
            UPD_SWWR: begin
                word_d = sw_wr_data & ~RSVD_MASK;
            end
            UPD_ALU: begin
                word_d[BIT_C] = alu_carry;
                word_d[BIT_Z] = alu_zero;
                word_d[BIT_S] = alu_sign;
                word_d[BIT_O] = alu_ovf;
            end
            UPD_HOLD: begin
                word_d = word_q;
            end
            default: begin
                word_d = word_q;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            word_q <= '0;
        else
            word_q <= word_d;
    end

    always_comb begin
        cur_word = word_q;
        next_u   = word_d[BIT_U];
    end

endmodule

// File: rtl/swu_stack_ptrs.sv
module swu_stack_ptrs #(
    parameter int SP_W   = 16,
    parameter int NUM_SP = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [$clog2(NUM_SP)-1:0] sel,
    input  logic                      wr_en,
    input  logic [SP_W-1:0]           wr_data,
    output logic [SP_W-1:0]           rd_data
);

    logic [SP_W-1:0] sp_q [NUM_SP];

    for (genvar g = 0; g < NUM_SP; g++) begin : g_sp
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                sp_q[g] <= '0;
            else if (wr_en && (sel == g))
                sp_q[g] <= wr_data;
        end
    end

    always_comb begin
        rd_data = sp_q[sel];
    end

endmodule

// File: rtl/status_word_unit.sv
module status_word_unit
    import swu_pkg::*;
#(
    parameter int SP_W        = 16,
    parameter int SWI_NUM_W   = 6,
    parameter int SWI_U_LIMIT = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 alu_flag_we,
    input  logic                 alu_carry,
    input  logic                 alu_zero,
    input  logic                 alu_sign,
    input  logic                 alu_ovf,
    input  logic                 sw_wr_en,
    input  logic [WORD_W-1:0]    sw_wr_data,
    input  logic                 sp_wr_en,
    input  logic [SP_W-1:0]      sp_wr_data,
    input  logic                 irq_req,
    input  logic [IPL_W-1:0]     irq_prio,
    input  logic                 swi_exec,
    input  logic [SWI_NUM_W-1:0] swi_num,
    output logic                 irq_accept,
    output logic [WORD_W-1:0]    save_word,
    output logic [WORD_W-1:0]    status_word,
    output logic                 bank_sel,
    output logic [SP_W-1:0]      sp_active
);

    logic [WORD_W-1:0] cur_word;
    logic              next_u;
    logic              accept;

    swu_accept u_accept (
        .irq_req  (irq_req),
        .irq_prio (irq_prio),
        .swi_exec (swi_exec),
        .i_flag   (cur_word[BIT_I]),
        .cur_ipl  (cur_word[IPL_LSB +: IPL_W]),
        .accept   (accept)
    );

    swu_status_reg #(
        .SWI_NUM_W   (SWI_NUM_W),
        .SWI_U_LIMIT (SWI_U_LIMIT)
    ) u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept      (accept),
        .irq_prio    (irq_prio),
        .swi_exec    (swi_exec),
        .swi_num     (swi_num),
        .sw_wr_en    (sw_wr_en),
        .sw_wr_data  (sw_wr_data),
        .alu_flag_we (alu_flag_we),
        .alu_carry   (alu_carry),
        .alu_zero    (alu_zero),
        .alu_sign    (alu_sign),
        .alu_ovf     (alu_ovf),
        .cur_word    (cur_word),
        .next_u      (next_u)
    );

    swu_stack_ptrs #(
        .SP_W   (SP_W),
        .NUM_SP (2)
    ) u_sp (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (next_u),
        .wr_en   (sp_wr_en),
        .wr_data (sp_wr_data),
        .rd_data (sp_active)
    );

    always_comb begin
        irq_accept  = accept;
        save_word   = cur_word;
        status_word = cur_word;
        bank_sel    = cur_word[BIT_B];
    end

endmodule

// File: rtl/swu_checker.sv
module swu_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        irq_req,
    input logic [2:0]  irq_prio,
    input logic        swi_exec,
    input logic [5:0]  swi_num,
    input logic        irq_accept,
    input logic [15:0] status_word,
    input logic        bank_sel
);

    assert_accept_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_accept |-> (irq_req && !swi_exec && status_word[6] &&
                        (irq_prio > status_word[14:12])));

    assert_accept_update_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_accept |=> (!status_word[6] && status_word[14:12] == $past(irq_prio)));

    assert_accept_user_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_accept |=> !status_word[7]);

    assert_swi_high_keeps_u_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (swi_exec && swi_num >= 6'd32) |=> (status_word[7] == $past(status_word[7]) && !status_word[6]));

    assert_reserved_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (status_word[11:8] == 4'd0 && !status_word[15]));

    assert_bank_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bank_sel == status_word[4]);

endmodule

bind status_word_unit swu_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_req     (irq_req),
    .irq_prio    (irq_prio),
    .swi_exec    (swi_exec),
    .swi_num     (swi_num),
    .irq_accept  (irq_accept),
    .status_word (status_word),
    .bank_sel    (bank_sel)
);

// File: tb/status_word_unit_tb.sv
`timescale 1ns/1ps
module status_word_unit_tb;

    typedef struct {
        logic [15:0] word;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alu_flag_we = 1'b0, alu_carry = 1'b0, alu_zero = 1'b0, alu_sign = 1'b0, alu_ovf = 1'b0;
    logic        sw_wr_en = 1'b0;
    logic [15:0] sw_wr_data = '0;
    logic        sp_wr_en = 1'b0;
    logic [15:0] sp_wr_data = '0;
    logic        irq_req = 1'b0;
    logic [2:0]  irq_prio = '0;
    logic        swi_exec = 1'b0;
    logic [5:0]  swi_num = '0;
    logic        irq_accept;
    logic [15:0] save_word, status_word, sp_active;
    logic        bank_sel;

    // staged stimulus
    logic        s_alu, s_c, s_z, s_s, s_o, s_sw, s_spw, s_req, s_swi;
    logic [15:0] s_data, s_spd;
    logic [2:0]  s_prio;
    logic [5:0]  s_num;

    // reference model
    logic [15:0] m_word = '0;
    logic [15:0] m_isp = '0;
    logic [15:0] m_usp = '0;

    exp_t exp_q[$];
    int   total = 0;
    int   bad = 0;

    always #5 clk = ~clk;

    status_word_unit u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .alu_flag_we (alu_flag_we),
        .alu_carry   (alu_carry),
        .alu_zero    (alu_zero),
        .alu_sign    (alu_sign),
        .alu_ovf     (alu_ovf),
        .sw_wr_en    (sw_wr_en),
        .sw_wr_data  (sw_wr_data),
        .sp_wr_en    (sp_wr_en),
        .sp_wr_data  (sp_wr_data),
        .irq_req     (irq_req),
        .irq_prio    (irq_prio),
        .swi_exec    (swi_exec),
        .swi_num     (swi_num),
        .irq_accept  (irq_accept),
        .save_word   (save_word),
        .status_word (status_word),
        .bank_sel    (bank_sel),
        .sp_active   (sp_active)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_stage();
        s_alu = 0; s_c = 0; s_z = 0; s_s = 0; s_o = 0;
        s_sw = 0; s_data = '0; s_spw = 0; s_spd = '0;
        s_req = 0; s_prio = '0; s_swi = 0; s_num = '0;
    endtask

    // Driver: applies staged inputs for one cycle and queues the expected word
    task automatic tick(input string tag);
        logic [15:0] nxt;
        logic        e_acc;
        logic [15:0] e_sp;
        exp_t        item;
        @(posedge clk);
        #2;
        alu_flag_we = s_alu; alu_carry = s_c; alu_zero = s_z; alu_sign = s_s; alu_ovf = s_o;
        sw_wr_en = s_sw; sw_wr_data = s_data; sp_wr_en = s_spw; sp_wr_data = s_spd;
        irq_req = s_req; irq_prio = s_prio; swi_exec = s_swi; swi_num = s_num;
        #1;
        e_acc = s_req && !s_swi && m_word[6] && (s_prio > m_word[14:12]);
        nxt = m_word;
        if (e_acc) begin
            nxt[6] = 1'b0; nxt[7] = 1'b0; nxt[14:12] = s_prio;
        end else if (s_swi) begin
            nxt[6] = 1'b0;
            if (s_num < 6'd32) nxt[7] = 1'b0;
        end else if (s_sw) begin
            nxt = s_data & 16'h70FF;
        end else if (s_alu) begin
            nxt[0] = s_c; nxt[2] = s_z; nxt[3] = s_s; nxt[5] = s_o;
        end
        e_sp = nxt[7] ? m_usp : m_isp;
        chk(irq_accept == e_acc, {"R2 accept ", tag}, 32'(irq_accept), 32'(e_acc));
        if (e_acc)
            chk(save_word == m_word, {"R3 save ", tag}, 32'(save_word), 32'(m_word));
        chk(sp_active == e_sp, {"R10 sp ", tag}, 32'(sp_active), 32'(e_sp));
        if (s_spw) begin
            if (nxt[7]) m_usp = s_spd;
            else        m_isp = s_spd;
        end
        m_word = nxt;
        item.word = nxt;
        item.tag  = tag;
        exp_q.push_back(item);
        clear_stage();
    endtask

    // Monitor: compares the registered word one edge after it was queued
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t it;
                it = exp_q.pop_front();
                chk(status_word == it.word, {"word ", it.tag}, 32'(status_word), 32'(it.word));
                chk(bank_sel == it.word[4], "R6 bank", 32'(bank_sel), 32'(it.word[4]));
            end
        end
    end

    initial begin
        #2000000;
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        clear_stage();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(status_word == 16'h0, "R1 word", 32'(status_word), 32'h0);
        chk(sp_active == 16'h0, "R1 sp", 32'(sp_active), 32'h0);
        chk(irq_accept == 1'b0, "R1 accept", 32'(irq_accept), 32'h0);

        s_sw = 1; s_data = 16'hFFFF; tick("R8 all ones");
        s_sw = 1; s_data = 16'h0040; tick("R8 enable");
        s_alu = 1; s_c = 1; s_s = 1; s_o = 1; tick("R7 alu a");
        s_alu = 1; s_z = 1; tick("R7 alu b");
        s_alu = 1; s_c = 1; s_z = 1; s_s = 1; s_o = 1; s_sw = 1; s_data = 16'h00C0; tick("R9 sw over alu");
        s_req = 1; s_prio = 3'd0; tick("R2 equal prio");
        s_req = 1; s_prio = 3'd3; s_spw = 1; s_spd = 16'h1234; tick("R10 accept write");
        s_req = 1; s_prio = 3'd7; tick("R2 masked");
        s_sw = 1; s_data = 16'h50C0; tick("R8 ipl5");
        s_spw = 1; s_spd = 16'hBEEF; tick("R5 usp write");
        tick("R5 usp read");
        s_req = 1; s_prio = 3'd5; tick("R2 ipl equal");
        s_req = 1; s_prio = 3'd6; s_sw = 1; s_data = 16'h0000; tick("R9 accept over sw");
        s_sw = 1; s_data = 16'h00D0; tick("R6 bank1");
        s_swi = 1; s_num = 6'd40; s_req = 1; s_prio = 3'd7; tick("R4 swi40");
        s_sw = 1; s_data = 16'h00D0; tick("R4 reload");
        s_swi = 1; s_num = 6'd31; tick("R4 swi31");
        s_sw = 1; s_data = 16'h0090; s_swi = 1; s_num = 6'd0; tick("R9 swi over sw");
        s_sw = 1; s_data = 16'h70C2; tick("R8 ipl7");
        s_req = 1; s_prio = 3'd7; tick("R2 top level");
        tick("R5 isp read");
        tick("idle");
        repeat (2) @(posedge clk);
        #1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule